// File: doc/BRIEF.md
# Parallel Flash Chip-Erase Command Controller

This block stands in for the command interface of a word-wide parallel NOR flash. A host drives an address bus, a data bus, a one-cycle write strobe and a one-cycle read strobe. A command decoder watches the write strobes for the chip-erase command. The command is six writes long: two unlock writes, a setup code, two more unlock writes and the erase code. When the last write is accepted, an internal engine takes over and the host drives no further control. The engine first programs every word of a small internal array to zero and checks each one. It then sets every word to all ones.

While the engine runs, the ready output is low. A read returns a status byte in place of array data, whatever the address. In that byte, bit 7 reads 0 and bits 6 and 2 toggle on every read. Writes are ignored while busy. When the erase finishes, the block goes back to array reads. An active-low hardware reset stops the engine at once. Words the engine has already rewritten keep their new contents, and all other words keep what they held before.

The decoder has six states. CMD_IDLE is the rest state. CMD_U1 follows the first unlock, CMD_U2 the second unlock, CMD_SETUP the setup code, CMD_U3 the third unlock and CMD_U4 the fourth unlock. A matching write moves the decoder to the next state. In CMD_U4, a matching write goes back to CMD_IDLE and starts the engine. A write that does not match sends the decoder to CMD_IDLE from any state. While the engine is busy, the decoder is held in CMD_IDLE.

The engine has four states: ENG_IDLE, ENG_PREPROG, ENG_VERIFY and ENG_ERASE. It moves from ENG_IDLE to ENG_PREPROG on start. Each step handles one word. After the last word, ENG_PREPROG moves to ENG_VERIFY, ENG_VERIFY moves to ENG_ERASE, and ENG_ERASE moves to ENG_IDLE. If a verify finds a word that is not zero, the engine goes back to ENG_PREPROG at that word.

Top module: `flash_erase_ctrl`

## Requirements
- R1: While reset is held, ready is 1 and rd_data is 0.
- R2: The six writes below start the erase, and ready is 0 from the clock edge that accepts the sixth write. The writes, as (word address, data) in order, are: (0x555, 0xAA), (0x2AA, 0x55), (0x555, 0x80), (0x555, 0xAA), (0x2AA, 0x55), (0x555, 0x10). Only the low 11 address bits are compared.
- R3: A write with a wrong address or wrong data at any step returns the decoder to idle. The command must then start again from the first unlock write.
- R4: With WORDS words in the array, ready stays 0 for exactly 3*WORDS clock cycles. This is one cycle per word in each of the three phases.
- R5: A read issued while busy returns a status byte one cycle later. Bit 7 is 0. Bits 6 and 2 both equal a toggle bit and all other bits are 0. The toggle bit is 0 on the first read of each operation and flips on every later busy read. The address has no effect on a busy read.
- R6: Writes made while busy are ignored. They do not start another erase and do not leave the decoder part-way through a sequence.
- R7: After the erase completes, every word reads 0xFF.
- R8: Hardware reset drives ready to 1 at once, without waiting for a clock. Words not yet preprogrammed keep their earlier contents.
- R9: Preprogramming writes zero to one word per clock in ascending order, starting one cycle after the sixth write. Word j is zeroed by the clock edge j+1 edges after that write. Every word verifies as zero before the erase phase begins.
- R10: When idle, a read returns the array word at the low address bits one cycle later. The initial contents of word i are (i*0x3B + 0x5A) mod 256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| bus_addr | input | ADDR_W | Host word address |
| bus_wdata | input | DATA_W | Host write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| rd_data | output | DATA_W | Read result, valid the cycle after bus_re |
| ready | output | 1 | 1 when idle, 0 while the erase runs |

## Verification
A decoder stuck in a middle state would show up at the ports as a spurious erase start. This would happen on the first partial sequence written after an earlier mismatch or after a busy period. Ready would drop within one clock of the offending write.

A wrong engine phase or a wrong word pointer shows up as a busy time other than 3*WORDS. An aborted erase whose zeroed words do not match the abort cycle shows up on the array reads after reset. So does any word that is not 0xFF after completion. A broken status path shows on the very next busy read.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

    typedef enum logic [2:0] {
        CMD_IDLE,
        CMD_U1,
        CMD_U2,
        CMD_SETUP,
        CMD_U3,
        CMD_U4
    } cmd_state_e;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_PREPROG,
        ENG_VERIFY,
        ENG_ERASE
    } eng_state_e;

    localparam int          CMD_AW      = 11;
    localparam logic [10:0] ADDR_KEY_HI = 11'h555;
    localparam logic [10:0] ADDR_KEY_LO = 11'h2AA;
    localparam logic [7:0]  CODE_KEY1   = 8'hAA;
    localparam logic [7:0]  CODE_KEY2   = 8'h55;
    localparam logic [7:0]  CODE_SETUP  = 8'h80;
    localparam logic [7:0]  CODE_CHIP   = 8'h10;

    // busy status byte: bit7 = 0, bits 6 and 2 carry the toggle
    function automatic logic [7:0] status_byte(input logic tgl);
        return {1'b0, tgl, 3'b000, tgl, 2'b00};
    endfunction

endpackage

// File: rtl/flash_word_array.sv
module flash_word_array #(
    parameter int WORDS  = 16,
    parameter int DATA_W = 8,
    parameter int AW     = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_a_addr,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [AW-1:0]     rd_b_addr,
    output logic [DATA_W-1:0] rd_b_data
);

    logic [DATA_W-1:0] mem [WORDS];

    // non-volatile contents: loaded once, never cleared by reset
    initial begin
        for (int i = 0; i < WORDS; i++) begin
            mem[i] <= DATA_W'(i * 59 + 90);
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_a_data = mem[rd_a_addr];
    assign rd_b_data = mem[rd_b_addr];

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_erase_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              busy,
    output logic              start
);

    cmd_state_e         cmd_q, cmd_d;
    logic [CMD_AW-1:0]  want_addr;
    logic [7:0]         want_code;
    logic               hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmd_q <= CMD_IDLE;
        else        cmd_q <= cmd_d;
    end

    always_comb begin
        unique case (cmd_q)
            CMD_IDLE:  begin want_addr = ADDR_KEY_HI; want_code = CODE_KEY1;  end
            CMD_U1:    begin want_addr = ADDR_KEY_LO; want_code = CODE_KEY2;  end
            CMD_U2:    begin want_addr = ADDR_KEY_HI; want_code = CODE_SETUP; end
            CMD_SETUP: begin want_addr = ADDR_KEY_HI; want_code = CODE_KEY1;  end
            CMD_U3:    begin want_addr = ADDR_KEY_LO; want_code = CODE_KEY2;  end
            CMD_U4:    begin want_addr = ADDR_KEY_HI; want_code = CODE_CHIP;  end
            default:   begin want_addr = ADDR_KEY_HI; want_code = CODE_KEY1;  end
        endcase
        hit = (bus_addr[CMD_AW-1:0] == want_addr) &&
              (bus_wdata == DATA_W'(want_code));
    end

    always_comb begin
        cmd_d = cmd_q;
        start = 1'b0;
        if (busy) begin
            cmd_d = CMD_IDLE;
        end else if (bus_we) begin
            if (!hit) begin
                cmd_d = CMD_IDLE;
            end else begin
                unique case (cmd_q)
                    CMD_IDLE:  cmd_d = CMD_U1;
                    CMD_U1:    cmd_d = CMD_U2;
                    CMD_U2:    cmd_d = CMD_SETUP;
                    CMD_SETUP: cmd_d = CMD_U3;
                    CMD_U3:    cmd_d = CMD_U4;
                    CMD_U4:    begin cmd_d = CMD_IDLE; start = 1'b1; end
                    default:   cmd_d = CMD_IDLE;
                endcase
            end
        end
    end

    // R6: a write that lands while busy never moves the decoder
    assert_busy_holds_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> cmd_q == CMD_IDLE);

endmodule

// File: rtl/flash_erase_engine.sv
module flash_erase_engine
    import flash_erase_pkg::*;
#(
    parameter int WORDS  = 16,
    parameter int DATA_W = 8,
    parameter int AW     = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] vdata,
    output logic              busy,
    output logic              wr_en,
    output logic [AW-1:0]     ptr,
    output logic [DATA_W-1:0] wr_data
);

    localparam logic [AW-1:0] LAST = AW'(WORDS - 1);

    eng_state_e      state_q, state_d;
    logic [AW-1:0]   ptr_q, ptr_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ENG_IDLE;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end

    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        unique case (state_q)
            ENG_IDLE: begin
                if (start) begin
                    state_d = ENG_PREPROG;
                    ptr_d   = '0;
                end
            end
            ENG_PREPROG: begin
                if (ptr_q == LAST) begin
                    state_d = ENG_VERIFY;
                    ptr_d   = '0;
                end else begin
                    ptr_d = ptr_q + 1'b1;
                end
            end
            ENG_VERIFY: begin
                if (vdata != '0) begin
                    state_d = ENG_PREPROG;
                end else if (ptr_q == LAST) begin
                    state_d = ENG_ERASE;
                    ptr_d   = '0;
                end else begin
                    ptr_d = ptr_q + 1'b1;
                end
            end
            ENG_ERASE: begin
                if (ptr_q == LAST) begin
                    state_d = ENG_IDLE;
                    ptr_d   = '0;
                end else begin
                    ptr_d = ptr_q + 1'b1;
                end
            end
            default: begin
                state_d = ENG_IDLE;
                ptr_d   = '0;
            end
        endcase
    end

    always_comb begin
        busy    = (state_q != ENG_IDLE);
        ptr     = ptr_q;
        wr_en   = 1'b0;
        wr_data = '0;
        unique case (state_q)
            ENG_PREPROG: begin wr_en = 1'b1; wr_data = '0; end
            ENG_ERASE:   begin wr_en = 1'b1; wr_data = '1; end
            default:     begin wr_en = 1'b0; wr_data = '0; end
        endcase
    end

    // R9: every word seen in the verify phase already holds zero
    assert_verify_sees_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ENG_VERIFY |-> vdata == '0);

    // R4: preprogram is only ever left for verify
    assert_preprog_to_verify_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ENG_PREPROG && state_q != ENG_PREPROG) |-> state_q == ENG_VERIFY);

    // R4: busy ends only after the last erase word
    assert_done_after_last_erase_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(state_q) == ENG_ERASE && $past(ptr_q) == LAST));

endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
    import flash_erase_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8,
    parameter int WORDS  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DATA_W-1:0] rd_data,
    output logic              ready
);

    localparam int AW = $clog2(WORDS);

    logic              start;
    logic              busy;
    logic              wr_en;
    logic [AW-1:0]     ptr;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] vdata;
    logic [DATA_W-1:0] host_word;
    logic              tgl_q;

    flash_cmd_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .busy      (busy),
        .start     (start)
    );

    flash_erase_engine #(.WORDS(WORDS), .DATA_W(DATA_W), .AW(AW)) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .vdata   (vdata),
        .busy    (busy),
        .wr_en   (wr_en),
        .ptr     (ptr),
        .wr_data (wr_data)
    );

    flash_word_array #(.WORDS(WORDS), .DATA_W(DATA_W), .AW(AW)) u_arr (
        .clk       (clk),
        .wr_en     (wr_en),
        .wr_addr   (ptr),
        .wr_data   (wr_data),
        .rd_a_addr (ptr),
        .rd_a_data (vdata),
        .rd_b_addr (bus_addr[AW-1:0]),
        .rd_b_data (host_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
            tgl_q   <= 1'b0;
        end else begin
            if (start) begin
                tgl_q <= 1'b0;
            end else if (busy && bus_re) begin
                tgl_q <= ~tgl_q;
            end
            if (bus_re) begin
                rd_data <= busy ? DATA_W'(status_byte(tgl_q)) : host_word;
            end
        end
    end

    assign ready = ~busy;

    // R6: no start is raised while an erase is running
    assert_no_start_when_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> ready);

    // R5: a busy read never shows bit 7 set
    assert_busy_read_dq7_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && !ready) |=> rd_data[7] == 1'b0);

    // R2: ready drops only on the edge that accepts the sixth write
    assert_ready_falls_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> $past(start));

endmodule

// File: tb/tb_flash_erase_ctrl.sv
`timescale 1ns/1ps
module tb_flash_erase_ctrl;

    localparam int ADDR_W = 11;
    localparam int DATA_W = 8;
    localparam int WORDS  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic              bus_we = 1'b0;
    logic              bus_re = 1'b0;
    logic [DATA_W-1:0] rd_data;
    logic              ready;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [DATA_W-1:0] exp_q[$];
    string             tag_q[$];
    logic              re_s = 1'b0;
    bit                tb_tgl = 0;
    int                run = 0;
    int                last_run = 0;

    always #2.5 clk = ~clk;

    flash_erase_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .rd_data   (rd_data),
        .ready     (ready)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'(i * 8'h3B + 8'h5A);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [10:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [10:0] a, input logic [7:0] e, input string req);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(req);
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic busy_rd(input logic [10:0] a);
        rd(a, tb_tgl ? 8'h44 : 8'h00, "R5");
        tb_tgl = ~tb_tgl;
    endtask

    task automatic erase_seq();
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h80);
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h10);
    endtask

    task automatic wrap_up();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // scoreboard monitor
    always @(posedge clk) re_s <= bus_re;
    always @(negedge clk) begin
        if (re_s && rst_n) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R10 actual=0x%0h expected=no read pending", rd_data);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, 32'(rd_data), 32'(e));
            end
        end
    end

    // busy run-length monitor
    always @(negedge clk) begin
        if (!rst_n) run = 0;
        else if (!ready) run++;
        else if (run != 0) begin last_run = run; run = 0; end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            wrap_up();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 ready", 32'(ready), 32'd1);
        check("R1 rd_data", 32'(rd_data), 32'd0);
        @(negedge clk) rst_n = 1'b1;

        // R10 idle reads, upper address bits ignored
        rd(11'h003, pat(3), "R10");
        rd(11'h00F, pat(15), "R10");
        rd(11'h7F3, pat(3), "R10");

        // R3: wrong final code
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h80);
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h11);
        repeat (2) @(negedge clk);
        check("R3 wrong code", 32'(ready), 32'd1);
        // R3: wrong unlock address, then the rest of the sequence
        wr(11'h555, 8'hAA); wr(11'h2AB, 8'h55); wr(11'h555, 8'h80);
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h10);
        repeat (2) @(negedge clk);
        check("R3 wrong addr", 32'(ready), 32'd1);
        // R3: wrong setup code
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h90);
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h10);
        repeat (2) @(negedge clk);
        check("R3 wrong setup", 32'(ready), 32'd1);
        rd(11'h000, pat(0), "R3 array untouched");

        // R8/R9: abort after five preprogram edges
        erase_seq();
        check("R2 start", 32'(ready), 32'd0);
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b0;
        #1 check("R8 async ready", 32'(ready), 32'd1);
        @(negedge clk) rst_n = 1'b1;
        for (int i = 0; i < WORDS; i++) begin
            if (i < 5) rd(11'(i), 8'h00, "R9 preprogrammed");
            else       rd(11'(i), pat(i), "R8 kept");
        end

        // full erase with busy reads and ignored writes
        erase_seq();
        check("R2 start", 32'(ready), 32'd0);
        tb_tgl = 0;
        busy_rd(11'h001);
        busy_rd(11'h555);
        busy_rd(11'h00A);
        // R6: partial sequence while busy
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h80); wr(11'h555, 8'hAA);
        busy_rd(11'h002);
        // R6: full sequence while busy
        erase_seq();
        while (!ready) @(negedge clk);
        @(negedge clk);
        check("R4 busy cycles", 32'(last_run), 32'(3 * WORDS));
        repeat (3) @(negedge clk);
        check("R6 no restart", 32'(ready), 32'd1);
        for (int i = 0; i < WORDS; i++) rd(11'(i), 8'hFF, "R7");
        // R6: finishing the partial sequence written while busy starts nothing
        wr(11'h2AA, 8'h55); wr(11'h555, 8'h10);
        repeat (3) @(negedge clk);
        check("R6 partial ignored", 32'(ready), 32'd1);

        // decoder still works after all that
        erase_seq();
        check("R2 restart", 32'(ready), 32'd0);
        while (!ready) @(negedge clk);
        @(negedge clk);
        check("R4 busy cycles again", 32'(last_run), 32'(3 * WORDS));
        rd(11'h005, 8'hFF, "R7");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R10 actual=%0d pending reads expected=0", exp_q.size());
        end
        done = 1;
        wrap_up();
    end

endmodule